// File: doc/BRIEF.md
# Load-Use Interlock Cycle Accountant

This block follows the instructions that an in-order core model retires, one descriptor per valid beat. It keeps a running total of the cycles the program has spent. It also works out the extra stall cycles that arise when a loaded register is read too soon after the load. A narrow load (byte or halfword) leaves its result unavailable for two cycles. A full-word load leaves it unavailable for one cycle. An intervening instruction that takes more than one cycle covers the whole gap, and a taken branch wipes out any pending hazard.

Each stall is charged to the load that produced it, not to the instruction that consumed the value. The report names the load by its position in the stream, so a cost table built from the reports never shows a stall on the consumer. Code that is entered directly at the consumer therefore sees no stall. The block does not decode instructions and does not model the pipeline. It only accounts for cycles from the descriptor fields.

Top module: `lu_interlock_acct`

## Requirements
- R1: On a beat with no interlock, `total_cycles` grows by `base_cyc` when `cond_pass` is 1. The increase is visible one clock after the beat. Cycles with `in_valid` low leave the total unchanged.
- R2: A narrow load (`load_kind` 2'b10 or 2'b11) that passes its condition is followed immediately by an instruction that passes its condition and reads the loaded register through a source with its valid bit set. That beat costs 2 extra cycles.
- R3: A narrow load is followed by one instruction that does not read the loaded register and costs exactly one cycle. If the next instruction then reads the loaded register, it costs 1 extra cycle.
- R4: An instruction that passes its condition with `base_cyc` greater than 1 closes a pending interlock. A later read of the loaded register then adds nothing.
- R5: A word load (`load_kind` 2'b01) adds 1 extra cycle only when the instruction right after it reads the loaded register. A read one instruction later adds nothing.
- R6: An instruction whose condition fails costs exactly 1 cycle, whatever its `base_cyc`. It opens no window, even if it is a load. Its sources never match. It counts as a single-cycle intervening instruction.
- R7: A beat with `br_taken` set clears any pending interlock after that beat is charged. The instruction at the branch target therefore never stalls.
- R8: Every beat that incurs stall cycles produces exactly one report, one clock after the beat. The report raises `rpt_valid`, gives the stall count (1 or 2) on `rpt_stall`, and gives on `rpt_idx` the sequence number of the load that caused it. Valid beats are numbered from 0 after reset. No report is made for beats without a stall.
- R9: A load that passes its condition replaces any pending interlock with its own window. A load whose destination is also one of its own sources causes no stall on itself.
- R10: After reset, `total_cycles` is 0, `rpt_valid` is 0, and no interlock is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor valid this cycle |
| cond_pass | input | 1 | Instruction condition passed |
| load_kind | input | 2 | 00 none, 01 word load, 10/11 narrow load |
| dst_reg | input | 4 | Destination register index |
| src_reg | input | 12 | Three 4-bit source indices, source i in bits [4i+3:4i] |
| src_vld | input | 3 | Valid bit per source |
| base_cyc | input | 4 | Base cycle cost |
| br_taken | input | 1 | Instruction is a taken branch |
| total_cycles | output | 64 | Running cycle total |
| rpt_valid | output | 1 | Stall report valid |
| rpt_idx | output | 16 | Sequence number of the charged load |
| rpt_stall | output | 2 | Stall cycles charged |

## Verification
Two functions can fall on the same beat. The first is a load that consumes the register of a still-pending load: it must report a stall against the older load and open its own window in the same cycle. The second is a taken branch that reads a pending register: it must be charged its stall and still clear the window. Directed sequences put both cases in one beat. The bench then checks the report index of the older load and the stall seen by the next instruction (either the new window or no stall at all). Randomised streams over a four-register pool hit these overlaps often and are judged against a bench model of the window rules.

// File: rtl/lu_acct_pkg.sv
package lu_acct_pkg;
  localparam int REG_W  = 4;
  localparam int NSRC   = 3;
  localparam int BASE_W = 4;
  localparam int IDX_W  = 16;
  localparam int TOT_W  = 64;

  typedef enum logic [1:0] {
    LK_NONE  = 2'b00,
    LK_WORD  = 2'b01,
    LK_NARW  = 2'b10,
    LK_NARW2 = 2'b11
  } load_kind_e;

  // cycle cost actually spent by one instruction
  function automatic logic [BASE_W-1:0] f_cost(input logic cond, input logic [BASE_W-1:0] base);
    return cond ? base : BASE_W'(1);
  endfunction

  // window width a load opens: 2 for narrow, 1 for word, 0 for no load
  function automatic logic [1:0] f_window(input logic [1:0] kind);
    case (kind)
      LK_WORD: return 2'd1;
      LK_NARW, LK_NARW2: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lu_hazard_match.sv
module lu_hazard_match
  import lu_acct_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = REG_W
) (
  input  logic           cond_pass,
  input  logic           pend_vld,
  input  logic [W-1:0]   pend_reg,
  input  logic [N*W-1:0] src_reg,
  input  logic [N-1:0]   src_vld,
  output logic           use_hit
);
  logic [N-1:0] per_src;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign per_src[i] = src_vld[i] && (src_reg[i*W +: W] == pend_reg);
  end

  assign use_hit = cond_pass && pend_vld && (|per_src);
endmodule

// File: rtl/lu_window_tracker.sv
module lu_window_tracker
  import lu_acct_pkg::*;
#(
  parameter int W   = REG_W,
  parameter int IW  = IDX_W,
  parameter int BW  = BASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          cond_pass,
  input  logic [1:0]    load_kind,
  input  logic [W-1:0]  dst_reg,
  input  logic [BW-1:0] cost,
  input  logic          br_taken,
  input  logic          use_hit,
  input  logic [IW-1:0] cur_idx,
  output logic          pend_vld,
  output logic [W-1:0]  pend_reg,
  output logic [1:0]    pend_win,
  output logic [IW-1:0] pend_idx
);
  logic       opens;
  logic [1:0] new_win;

  assign new_win = f_window(load_kind);
  assign opens   = in_valid && cond_pass && (new_win != 2'd0) && !br_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_reg <= '0;
      pend_win <= 2'd0;
      pend_idx <= '0;
    end else if (in_valid) begin
      if (opens) begin
        pend_vld <= 1'b1;
        pend_reg <= dst_reg;
        pend_win <= new_win;
        pend_idx <= cur_idx;
      end else if (br_taken || use_hit || (cost > BW'(1))) begin
        pend_vld <= 1'b0;
        pend_win <= 2'd0;
      end else if (pend_vld) begin
        pend_win <= pend_win - 2'd1;
        pend_vld <= (pend_win > 2'd1);
      end
    end
  end

  p_narrow_opens_two_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && cond_pass && load_kind[1] && !br_taken |=> pend_vld && pend_win == 2'd2);
  p_word_opens_one_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && cond_pass && load_kind == 2'b01 && !br_taken |=> pend_vld && pend_win == 2'd1);
  p_branch_clears_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && br_taken |=> !pend_vld);
  p_long_op_closes_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && cond_pass && load_kind == 2'b00 && cost > BW'(1) |=> !pend_vld);
  p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pend_vld) && $stable(pend_win));
endmodule

// File: rtl/lu_cycle_ledger.sv
module lu_cycle_ledger
  import lu_acct_pkg::*;
#(
  parameter int TW = TOT_W,
  parameter int IW = IDX_W,
  parameter int BW = BASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [BW-1:0] cost,
  input  logic [1:0]    stall,
  input  logic [IW-1:0] charged_idx,
  output logic [IW-1:0] seq_idx,
  output logic [TW-1:0] total_cycles,
  output logic          rpt_valid,
  output logic [IW-1:0] rpt_idx,
  output logic [1:0]    rpt_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_idx      <= '0;
      total_cycles <= '0;
      rpt_valid    <= 1'b0;
      rpt_idx      <= '0;
      rpt_stall    <= 2'd0;
    end else begin
      rpt_valid <= in_valid && (stall != 2'd0);
      if (in_valid) begin
        seq_idx      <= seq_idx + IW'(1);
        total_cycles <= total_cycles + TW'(cost) + TW'(stall);
        rpt_idx      <= charged_idx;
        rpt_stall    <= stall;
      end
    end
  end

  p_idle_total_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(total_cycles) && !rpt_valid);
  p_report_range_r8: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> rpt_stall != 2'd0);
endmodule

// File: rtl/lu_interlock_acct.sv
module lu_interlock_acct
  import lu_acct_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NS = NSRC,
  parameter int BW = BASE_W,
  parameter int IW = IDX_W,
  parameter int TW = TOT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           cond_pass,
  input  logic [1:0]     load_kind,
  input  logic [RW-1:0]  dst_reg,
  input  logic [NS*RW-1:0] src_reg,
  input  logic [NS-1:0]  src_vld,
  input  logic [BW-1:0]  base_cyc,
  input  logic           br_taken,
  output logic [TW-1:0]  total_cycles,
  output logic           rpt_valid,
  output logic [IW-1:0]  rpt_idx,
  output logic [1:0]     rpt_stall
);
  logic          pend_vld;
  logic [RW-1:0] pend_reg;
  logic [1:0]    pend_win;
  logic [IW-1:0] pend_idx;
  logic [IW-1:0] seq_idx;
  logic          use_hit;
  logic [BW-1:0] cost;
  logic [1:0]    stall;

  assign cost  = f_cost(cond_pass, base_cyc);
  assign stall = use_hit ? pend_win : 2'd0;

  lu_hazard_match #(.N(NS), .W(RW)) u_match (
    .cond_pass (cond_pass),
    .pend_vld  (pend_vld),
    .pend_reg  (pend_reg),
    .src_reg   (src_reg),
    .src_vld   (src_vld),
    .use_hit   (use_hit)
  );

  lu_window_tracker #(.W(RW), .IW(IW), .BW(BW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cond_pass (cond_pass),
    .load_kind (load_kind),
    .dst_reg   (dst_reg),
    .cost      (cost),
    .br_taken  (br_taken),
    .use_hit   (use_hit),
    .cur_idx   (seq_idx),
    .pend_vld  (pend_vld),
    .pend_reg  (pend_reg),
    .pend_win  (pend_win),
    .pend_idx  (pend_idx)
  );

  lu_cycle_ledger #(.TW(TW), .IW(IW), .BW(BW)) u_ledger (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .cost         (cost),
    .stall        (stall),
    .charged_idx  (pend_idx),
    .seq_idx      (seq_idx),
    .total_cycles (total_cycles),
    .rpt_valid    (rpt_valid),
    .rpt_idx      (rpt_idx),
    .rpt_stall    (rpt_stall)
  );

  p_fail_no_stall_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !cond_pass |=> !rpt_valid);
  p_report_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && use_hit |=> rpt_valid && rpt_stall == $past(pend_win));
  p_report_names_load_r8: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> rpt_idx < seq_idx);
endmodule

// File: tb/lu_interlock_acct_tb.sv
module lu_interlock_acct_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, cond_pass, br_taken;
  logic [1:0]  load_kind;
  logic [3:0]  dst_reg, base_cyc;
  logic [11:0] src_reg;
  logic [2:0]  src_vld;
  logic [63:0] total_cycles;
  logic        rpt_valid;
  logic [15:0] rpt_idx;
  logic [1:0]  rpt_stall;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  bit          m_live;
  int          m_reg, m_left, m_from, m_seq;
  longint      m_total;
  bit          e_rv;
  int          e_ri, e_rs;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_interlock_acct u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
    .load_kind(load_kind), .dst_reg(dst_reg), .src_reg(src_reg),
    .src_vld(src_vld), .base_cyc(base_cyc), .br_taken(br_taken),
    .total_cycles(total_cycles), .rpt_valid(rpt_valid),
    .rpt_idx(rpt_idx), .rpt_stall(rpt_stall)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: returns stall for this instruction and advances state
  function automatic int model_step(bit c, int k, int d, int s0, int s1, int s2,
                                    int sv, int b, bit br);
    int spent, st;
    bit rd;
    spent = c ? b : 1;
    rd = 0;
    if (c && m_live)
      rd = (sv[0] && s0 == m_reg) || (sv[1] && s1 == m_reg) || (sv[2] && s2 == m_reg);
    st = rd ? m_left : 0;
    e_rv = (st > 0);
    if (st > 0) begin e_ri = m_from; e_rs = st; end
    m_total += spent + st;
    if (br) m_live = 0;
    else if (c && k != 0) begin
      m_live = 1; m_reg = d; m_left = (k == 1) ? 1 : 2; m_from = m_seq;
    end else if (rd || spent > 1) m_live = 0;
    else if (m_live) begin
      m_left--;
      if (m_left == 0) m_live = 0;
    end
    m_seq = (m_seq + 1) & 16'hFFFF;
    return st;
  endfunction

  task automatic beat(input string tag, input bit c, input int k, input int d,
                      input int s0, input int s1, input int s2, input int sv,
                      input int b, input bit br);
    int st;
    @(negedge clk);
    in_valid = 1; cond_pass = c; load_kind = 2'(k); dst_reg = 4'(d);
    src_reg = {4'(s2), 4'(s1), 4'(s0)}; src_vld = 3'(sv); base_cyc = 4'(b);
    br_taken = br;
    st = model_step(c, k, d, s0, s1, s2, sv, b, br);
    @(posedge clk); #1;
    check({tag, " total"}, total_cycles, m_total);
    check({tag, " rpt_valid"}, rpt_valid, e_rv);
    if (e_rv) begin
      check({tag, " rpt_idx"}, rpt_idx, e_ri);
      check({tag, " rpt_stall"}, rpt_stall, e_rs);
    end
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      @(posedge clk); #1;
      check("R1 idle total", total_cycles, m_total);
      check("R1 idle rpt", rpt_valid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused;
    rst = 1; in_valid = 0; cond_pass = 0; load_kind = 0; dst_reg = 0;
    src_reg = 0; src_vld = 0; base_cyc = 1; br_taken = 0;
    m_live = 0; m_reg = 0; m_left = 0; m_from = 0; m_seq = 0; m_total = 0;
    unused = $urandom(32'h1D2C);
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset total", total_cycles, 0);
    check("R10 reset rpt", rpt_valid, 0);
    @(negedge clk); rst = 0;

    // R1: plain costs, with an idle gap
    beat("R1 plain", 1, 0, 5, 6, 7, 8, 3'b111, 1, 0);
    beat("R1 base3", 1, 0, 5, 6, 7, 8, 3'b111, 3, 0);
    idle(2);
    // R2: narrow load then immediate use (load idx 2)
    beat("R2 load", 1, 2, 1, 9, 9, 9, 3'b001, 1, 0);
    beat("R2 use", 1, 0, 4, 9, 1, 9, 3'b010, 1, 0);
    // R3: narrow, single-cycle gap, then use
    beat("R3 load", 1, 3, 2, 9, 9, 9, 3'b001, 1, 0);
    beat("R3 gap", 1, 0, 4, 9, 9, 9, 3'b001, 1, 0);
    beat("R3 use", 1, 0, 4, 2, 9, 9, 3'b001, 1, 0);
    // R4: multi-cycle gap closes
    beat("R4 load", 1, 2, 3, 9, 9, 9, 3'b001, 1, 0);
    beat("R4 mul", 1, 0, 4, 9, 9, 9, 3'b001, 2, 0);
    beat("R4 use", 1, 0, 4, 3, 9, 9, 3'b001, 1, 0);
    // R6: skipped multiply acts as one-cycle gap
    beat("R6 load", 1, 2, 3, 9, 9, 9, 3'b001, 1, 0);
    beat("R6 skip", 0, 0, 4, 3, 9, 9, 3'b001, 2, 0);
    beat("R6 use", 1, 0, 4, 3, 9, 9, 3'b001, 1, 0);
    beat("R6 failed load", 0, 2, 7, 9, 9, 9, 3'b000, 3, 0);
    beat("R6 no window", 1, 0, 4, 7, 7, 7, 3'b111, 1, 0);
    // R5: word load
    beat("R5 load", 1, 1, 8, 9, 9, 9, 3'b001, 1, 0);
    beat("R5 use", 1, 0, 4, 8, 9, 9, 3'b001, 1, 0);
    beat("R5 load2", 1, 1, 8, 9, 9, 9, 3'b001, 1, 0);
    beat("R5 gap", 1, 0, 4, 9, 9, 9, 3'b001, 1, 0);
    beat("R5 late", 1, 0, 4, 8, 9, 9, 3'b001, 1, 0);
    // R7: branch reads pending reg and clears
    beat("R7 load", 1, 2, 6, 9, 9, 9, 3'b001, 1, 0);
    beat("R7 branch", 1, 0, 0, 6, 9, 9, 3'b001, 3, 1);
    beat("R7 target", 1, 0, 4, 6, 9, 9, 3'b001, 1, 0);
    // R9: self-source load, then load consuming pending one
    beat("R9 self", 1, 2, 5, 5, 9, 9, 3'b001, 1, 0);
    beat("R9 chain", 1, 1, 10, 5, 9, 9, 3'b001, 1, 0);
    beat("R9 new use", 1, 0, 4, 10, 9, 9, 3'b001, 1, 0);
    beat("R9 replace", 1, 2, 11, 9, 9, 9, 3'b001, 1, 0);
    beat("R9 replace2", 1, 1, 12, 9, 9, 9, 3'b001, 1, 0);
    beat("R9 old reg", 1, 0, 4, 11, 9, 9, 3'b001, 1, 0);

    // R8: random streams over a small register pool
    for (int i = 0; i < 3000; i++) begin
      int k;
      if ($urandom_range(0, 9) == 0) idle(1);
      k = $urandom_range(0, 5);
      beat("R8 random", ($urandom_range(0, 4) != 0), (k > 3) ? 0 : k,
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(1, 3),
           ($urandom_range(0, 9) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule